// File: doc/BRIEF.md
# Random-Rate Bus Request Generator

This block stands in for a processor on a shared bus when measuring arbitration behaviour. Most of the time it does local work. At a programmed rate it raises a bus request, waits for the grant and for the bus to go quiet, then holds the bus for a fixed number of clocks with its own identifier on the address lines. The clocks at which it asks for the bus come from a slot table. The table is refilled with pseudo-random entries each time the local work has walked through all of its slots.

Several instances with different seeds and identifiers are placed next to an arbiter. Each keeps its own count of the requests it has issued and of the clocks it has spent waiting. After a programmed number of clocks it stops asking for the bus and releases its pull on a shared activity line. When every master has done this, the bench knows the run is over. All pins are plain level signals sampled on the rising clock. There is no streaming data path, so no valid/ready handshake or back-pressure applies.

Top module: `bus_req_gen`

## Requirements
- R1: While rst_n is low and at the first clock after it rises, bus_req, busy_out and addr_oe are low, addr_out is zero, active_oe is high, and req_count and wait_count are zero. Reset also starts a table fill (R2).
- R2: A table fill clears all SLOTS entries and then makes one draw per clock. A draw takes the current value of a 16-bit shift register and reduces it modulo SLOTS to get a slot. The register shifts left and loads bit15^bit13^bit12^bit10 into bit 0. The register advances on every draw. A slot that is clear becomes set; a slot that is already set is skipped. Once RATE distinct slots are set, one further clock ends the fill. The register starts at 16'hB5A3 XOR (SEED_SEL*16'h0123), or at 1 if that value is zero.
- R3: The slot index advances once per clock spent in local work, but not while a fill runs or after the stop. When the index wraps from SLOTS-1 to 0, a new fill starts. Exactly RATE requests are issued over each pass of SLOTS index steps.
- R4: A local clock whose slot is set moves the block to requesting. bus_req is high from the next clock until and including the first clock on which bus_gnt is high. req_count rises by one on the edge where bus_req rises, and at no other time.
- R5: bus_gnt has no effect unless bus_req is high. After a grant the block waits while busy_in is high. It takes the bus at the edge that ends the first clock with busy_in low.
- R6: While the block owns the bus, busy_out and addr_oe are high and addr_out equals MASTER_ID, for exactly TENURE clocks. Local work then resumes. At all other times addr_out is zero.
- R7: wait_count rises by one for every clock spent requesting or waiting after the grant.
- R8: active_oe falls CLK_LIMIT clocks after reset release and stays low. After that no new request starts; a request already under way still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_gnt | input | 1 | Grant from the arbiter |
| busy_in | input | 1 | Bus-in-use line as seen from the bus |
| bus_req | output | 1 | Bus request |
| busy_out | output | 1 | High while this master holds the bus |
| addr_oe | output | 1 | Address output enable |
| addr_out | output | ID_W | Master identifier during tenure, zero otherwise |
| active_oe | output | 1 | High while the master pulls the shared activity line low |
| req_count | output | CNT_W | Number of requests issued |
| wait_count | output | CNT_W | Clocks spent waiting for the bus |

## Verification
Every result is due one edge after the clock that causes it. bus_req rises at the edge that ends the local clock that read a set slot, together with the req_count step. The wait state begins at the edge after a clock with bus_gnt high. busy_out, addr_oe and addr_out come up at the edge after busy_in is seen low in that wait state. wait_count steps at the same edges. active_oe falls at the CLK_LIMIT-th edge after reset release. The bench keeps a clock-by-clock reference built from these rules. It moves the reference forward at each rising edge, using the input values held since the previous falling edge. It compares every output at the next falling edge, so each expected value lines up with the register stage that produces it.

// File: rtl/bus_req_pkg.sv
package bus_req_pkg;

  typedef enum logic [1:0] {
    ST_LOCAL  = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ACK    = 2'd2,
    ST_TENURE = 2'd3
  } req_state_e;

  localparam logic [15:0] SEED_BASE = 16'hB5A3;
  localparam logic [15:0] SEED_MUL  = 16'h0123;

  // Starting value of the draw register for a given seed selector.
  function automatic logic [15:0] seed_for(input int unsigned sel);
    logic [15:0] s;
    s = SEED_BASE ^ 16'(sel * SEED_MUL);
    return (s == 16'h0000) ? 16'h0001 : s;
  endfunction

  // One shift step: x^16 + x^14 + x^13 + x^11 + 1.
  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

endpackage

// File: rtl/req_lfsr.sv
module req_lfsr
  import bus_req_pkg::*;
#(
  parameter int unsigned SEED_SEL = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  output logic [15:0] value
);

  localparam logic [15:0] INIT = seed_for(SEED_SEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= INIT;
    end else if (step) begin
      value <= lfsr_next(value);
    end
  end

endmodule

// File: rtl/req_schedule.sv
module req_schedule #(
  parameter int unsigned SLOTS = 1000,
  parameter int unsigned RATE  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        advance,
  input  logic [15:0] rnd,
  output logic        rnd_step,
  output logic        hit,
  output logic        ready
);

  localparam int unsigned IDX_W  = $clog2(SLOTS);
  localparam int unsigned PL_W   = $clog2(SLOTS + 1);
  localparam logic [15:0] SLOTS16 = 16'(SLOTS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);
  localparam logic [PL_W-1:0]  RATE_PL  = PL_W'(RATE);

  logic [SLOTS-1:0] table_q;
  logic [IDX_W-1:0] idx_q;
  logic [PL_W-1:0]  placed_q;
  logic             fill_q;
  logic [IDX_W-1:0] slot;
  logic             full;

  assign slot     = IDX_W'(rnd % SLOTS16);
  assign full     = (placed_q == RATE_PL);
  assign rnd_step = fill_q & ~full;
  assign ready    = ~fill_q;
  assign hit      = ~fill_q & table_q[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      table_q  <= '0;
      idx_q    <= '0;
      placed_q <= '0;
      fill_q   <= 1'b1;
    end else if (fill_q) begin
      if (full) begin
        fill_q <= 1'b0;
      end else if (!table_q[slot]) begin
        table_q[slot] <= 1'b1;
        placed_q      <= placed_q + 1'b1;
      end
    end else if (advance) begin
      if (idx_q == LAST_IDX) begin
        idx_q    <= '0;
        table_q  <= '0;
        placed_q <= '0;
        fill_q   <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/req_fsm.sv
module req_fsm
  import bus_req_pkg::*;
#(
  parameter int unsigned ID_W      = 3,
  parameter int unsigned MASTER_ID = 0,
  parameter int unsigned TENURE    = 8,
  parameter int unsigned CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic             hit,
  input  logic             stopped,
  input  logic             bus_gnt,
  input  logic             busy_in,
  output logic             advance,
  output logic             bus_req,
  output logic             busy_out,
  output logic             addr_oe,
  output logic [ID_W-1:0]  addr_out,
  output logic [CNT_W-1:0] req_count,
  output logic [CNT_W-1:0] wait_count
);

  localparam int unsigned TEN_W = $clog2(TENURE + 1);
  localparam logic [TEN_W-1:0] TEN_LAST = TEN_W'(TENURE - 1);
  localparam logic [ID_W-1:0]  MY_ID    = ID_W'(MASTER_ID);

  req_state_e       state_q;
  logic [TEN_W-1:0] ten_q;
  logic [CNT_W-1:0] req_q;
  logic [CNT_W-1:0] wait_q;

  assign advance    = (state_q == ST_LOCAL) && ready && !stopped;
  assign bus_req    = (state_q == ST_WAIT);
  assign busy_out   = (state_q == ST_TENURE);
  assign addr_oe    = (state_q == ST_TENURE);
  assign addr_out   = (state_q == ST_TENURE) ? MY_ID : '0;
  assign req_count  = req_q;
  assign wait_count = wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_LOCAL;
      ten_q   <= '0;
      req_q   <= '0;
      wait_q  <= '0;
    end else begin
      if (state_q == ST_WAIT || state_q == ST_ACK) begin
        wait_q <= wait_q + 1'b1;
      end
      case (state_q)
        ST_LOCAL: begin
          if (advance && hit) begin
            state_q <= ST_WAIT;
            req_q   <= req_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (bus_gnt) state_q <= ST_ACK;
        end
        ST_ACK: begin
          if (!busy_in) begin
            state_q <= ST_TENURE;
            ten_q   <= '0;
          end
        end
        ST_TENURE: begin
          if (ten_q == TEN_LAST) state_q <= ST_LOCAL;
          else                   ten_q   <= ten_q + 1'b1;
        end
        default: state_q <= ST_LOCAL;
      endcase
    end
  end

endmodule

// File: rtl/bus_req_gen.sv
module bus_req_gen #(
  parameter int unsigned SLOTS     = 1000,
  parameter int unsigned RATE      = 10,
  parameter int unsigned SEED_SEL  = 1,
  parameter int unsigned MASTER_ID = 0,
  parameter int unsigned ID_W      = 3,
  parameter int unsigned TENURE    = 8,
  parameter int unsigned CLK_LIMIT = 5000,
  parameter int unsigned CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_gnt,
  input  logic             busy_in,
  output logic             bus_req,
  output logic             busy_out,
  output logic             addr_oe,
  output logic [ID_W-1:0]  addr_out,
  output logic             active_oe,
  output logic [CNT_W-1:0] req_count,
  output logic [CNT_W-1:0] wait_count
);

  localparam int unsigned CLK_W = $clog2(CLK_LIMIT + 1);
  localparam logic [CLK_W-1:0] CLK_END = CLK_W'(CLK_LIMIT);

  logic [CLK_W-1:0] clk_q;
  logic             stopped;
  logic [15:0]      rnd;
  logic             rnd_step;
  logic             hit;
  logic             ready;
  logic             advance;

  assign stopped   = (clk_q == CLK_END);
  assign active_oe = ~stopped;

  always_ff @(posedge clk) begin
    if (!rst_n)        clk_q <= '0;
    else if (!stopped) clk_q <= clk_q + 1'b1;
  end

  req_lfsr #(.SEED_SEL(SEED_SEL)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (rnd_step),
    .value (rnd)
  );

  req_schedule #(.SLOTS(SLOTS), .RATE(RATE)) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .rnd      (rnd),
    .rnd_step (rnd_step),
    .hit      (hit),
    .ready    (ready)
  );

  req_fsm #(
    .ID_W(ID_W), .MASTER_ID(MASTER_ID), .TENURE(TENURE), .CNT_W(CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .hit        (hit),
    .stopped    (stopped),
    .bus_gnt    (bus_gnt),
    .busy_in    (busy_in),
    .advance    (advance),
    .bus_req    (bus_req),
    .busy_out   (busy_out),
    .addr_oe    (addr_oe),
    .addr_out   (addr_out),
    .req_count  (req_count),
    .wait_count (wait_count)
  );

endmodule

// File: rtl/bus_req_gen_chk.sv
module bus_req_gen_chk #(
  parameter int unsigned ID_W      = 3,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MASTER_ID = 0,
  parameter int unsigned TENURE    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_gnt,
  input logic             busy_in,
  input logic             bus_req,
  input logic             busy_out,
  input logic             addr_oe,
  input logic [ID_W-1:0]  addr_out,
  input logic             active_oe,
  input logic [CNT_W-1:0] req_count,
  input logic [CNT_W-1:0] wait_count
);

  logic [15:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= '0;
    else if (busy_out) run_q <= run_q + 16'd1;
    else               run_q <= '0;
  end

  // R4: request held until granted
  a_r4_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);

  // R4: count steps with each new request
  a_r4_count_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> req_count == $past(req_count) + CNT_W'(1));

  a_r4_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(bus_req) |-> $stable(req_count));

  // R5: never requesting and owning the bus together
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && busy_out));

  // R6: identifier shown throughout tenure
  a_r6_id_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    busy_out |-> addr_oe && addr_out == ID_W'(MASTER_ID));

  // R6: tenure length
  a_r6_tenure_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_out) |-> run_q == 16'(TENURE));

  // R7: each requesting clock is counted as waiting
  a_r7_wait_step: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> wait_count == $past(wait_count) + CNT_W'(1));

  // R8: stop is permanent and blocks new requests
  a_r8_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !active_oe |=> !active_oe);

  a_r8_no_req_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(active_oe));

endmodule

bind bus_req_gen bus_req_gen_chk #(
  .ID_W(ID_W), .CNT_W(CNT_W), .MASTER_ID(MASTER_ID), .TENURE(TENURE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_gnt    (bus_gnt),
  .busy_in    (busy_in),
  .bus_req    (bus_req),
  .busy_out   (busy_out),
  .addr_oe    (addr_oe),
  .addr_out   (addr_out),
  .active_oe  (active_oe),
  .req_count  (req_count),
  .wait_count (wait_count)
);

// File: tb/tb_bus_req_gen.sv
`timescale 1ns/1ps
module tb_bus_req_gen;

  localparam int SLOTS     = 1000;
  localparam int RATE      = 40;
  localparam int SEED_SEL  = 7;
  localparam int MASTER_ID = 5;
  localparam int ID_W      = 3;
  localparam int TENURE    = 8;
  localparam int CLK_LIMIT = 12000;
  localparam int CNT_W     = 16;
  localparam int RUN_CYC   = 13000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_gnt = 1'b0;
  logic busy_in = 1'b0;
  logic bus_req, busy_out, addr_oe, active_oe;
  logic [ID_W-1:0]  addr_out;
  logic [CNT_W-1:0] req_count, wait_count;

  always #10 clk = ~clk;

  bus_req_gen #(
    .SLOTS(SLOTS), .RATE(RATE), .SEED_SEL(SEED_SEL), .MASTER_ID(MASTER_ID),
    .ID_W(ID_W), .TENURE(TENURE), .CLK_LIMIT(CLK_LIMIT), .CNT_W(CNT_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .busy_in(busy_in),
    .bus_req(bus_req), .busy_out(busy_out), .addr_oe(addr_oe),
    .addr_out(addr_out), .active_oe(active_oe),
    .req_count(req_count), .wait_count(wait_count)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference rules from the requirements (R2 seed and shift step)
  function automatic logic [15:0] ref_seed(input int sel);
    logic [15:0] s;
    s = 16'hB5A3 ^ 16'(sel * 16'h0123);
    return (s == 16'h0) ? 16'h1 : s;
  endfunction

  function automatic logic [15:0] ref_step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // Reference state: 0 local, 1 requesting, 2 granted-waiting, 3 tenure
  bit [SLOTS-1:0] m_tab;
  int m_idx, m_placed, m_ten, m_st, m_clk, per_req, periods;
  bit m_fill;
  logic [15:0] m_lfsr;
  longint m_req, m_wait;

  task automatic model_reset();
    m_tab = '0; m_idx = 0; m_placed = 0; m_ten = 0; m_st = 0; m_clk = 0;
    m_fill = 1'b1; m_lfsr = ref_seed(SEED_SEL); m_req = 0; m_wait = 0;
    per_req = 0; periods = 0;
  endtask

  task automatic model_step();
    bit stopped, hit, adv;
    int slot;
    stopped = (m_clk == CLK_LIMIT);
    hit     = !m_fill && m_tab[m_idx];
    adv     = (m_st == 0) && !m_fill && !stopped;
    slot    = int'(m_lfsr) % SLOTS;
    if (m_fill) begin
      if (m_placed == RATE) m_fill = 1'b0;
      else begin
        if (!m_tab[slot]) begin m_tab[slot] = 1'b1; m_placed++; end
        m_lfsr = ref_step(m_lfsr);
      end
    end else if (adv) begin
      if (hit) per_req++;
      if (m_idx == SLOTS - 1) begin
        chk("R3", "requests per pass", per_req, RATE);
        per_req = 0; periods++;
        m_idx = 0; m_tab = '0; m_placed = 0; m_fill = 1'b1;
      end else m_idx++;
    end
    if (m_st == 1 || m_st == 2) m_wait++;
    case (m_st)
      0: if (adv && hit) begin m_st = 1; m_req++; end
      1: if (bus_gnt) m_st = 2;
      2: if (!busy_in) begin m_st = 3; m_ten = 0; end
      default: if (m_ten == TENURE - 1) m_st = 0; else m_ten++;
    endcase
    if (!stopped) m_clk++;
  endtask

  task automatic compare_all();
    chk("R2", "bus_req", bus_req, m_st == 1);
    chk("R5", "busy_out", busy_out, m_st == 3);
    chk("R6", "addr_oe", addr_oe, m_st == 3);
    chk("R6", "addr_out", addr_out, (m_st == 3) ? MASTER_ID : 0);
    chk("R8", "active_oe", active_oe, m_clk != CLK_LIMIT);
    chk("R4", "req_count", req_count, m_req);
    chk("R7", "wait_count", wait_count, m_wait);
  endtask

  initial begin
    int mode;
    void'($urandom(32'd20240611));
    mode = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "bus_req in reset", bus_req, 0);
    chk("R1", "busy_out in reset", busy_out, 0);
    chk("R1", "addr_oe in reset", addr_oe, 0);
    chk("R1", "addr_out in reset", addr_out, 0);
    chk("R1", "active_oe in reset", active_oe, 1);
    chk("R1", "req_count in reset", req_count, 0);
    chk("R1", "wait_count in reset", wait_count, 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < RUN_CYC; cyc++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
      if (cyc % 250 == 0) mode = int'($urandom % 3);
      case (mode)
        0: begin  // random grants (also when idle) and busy line
          bus_gnt = ($urandom % 4) == 0;
          busy_in = ($urandom % 2) == 0;
        end
        1: begin  // immediate grant, free bus
          bus_gnt = 1'b1;
          busy_in = 1'b0;
        end
        default: begin  // congested bus, rare grants
          bus_gnt = ($urandom % 8) == 0;
          busy_in = ($urandom % 8) != 0;
        end
      endcase
    end
    // R3: several full passes seen; R8: stopped at the end
    chk("R3", "passes completed", periods >= 3, 1);
    chk("R8", "active_oe after limit", active_oe, 0);
    chk("R4", "some requests issued", req_count > 0, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule